// File: doc/BRIEF.md
# Register Rename Unit

This block sits between decode and issue in an out-of-order core. Each cycle it takes a group of up to `GROUP_W` decoded instructions. Each instruction names two source registers and may name one destination register. For every destination that is written, the block hands out a fresh physical register, so two in-flight writers never share storage. This removes write-after-read and write-after-write ordering. Every source is translated to the physical register of its nearest older producer, so true read-after-write links are kept. The translation results appear combinationally in the same cycle as the request. The maps and the pool of free registers change at the next rising clock edge.

The block keeps two maps. The speculative map follows every renamed writer. The committed map follows only retired instructions. When an instruction retires, the commit port writes its mapping into the committed map and returns the register it displaced to the free pool. A flush copies the committed map over the speculative one and reclaims every register that the committed map does not hold. The pool has `SPEC_REGS` (41) registers beyond the `ARCH_REGS` (32) architectural ones.

Top module: `reg_rename`

## Requirements
- R1: A lane is a writer when its `grp_valid` and `grp_has_dst` bits are both set. When the group is accepted, each writer receives a physical register that was free. The writers, taken in ascending lane order, receive the lowest-numbered free registers in ascending order, so no two writers receive the same register.
- R2: A valid lane's source tag equals the speculative mapping of that source when no lower-numbered writer in the same group writes that register.
- R3: When lower-numbered writers in the same group write a lane's source or destination register, the source tag or previous tag of that lane equals the register newly given to the highest such writer.
- R4: `grp_ready` is 1 exactly when the number of free registers is at least the number of writers in the group. If the group is not accepted (ready low or no valid lane), the maps and the free pool stay unchanged.
- R5: A commit (`cmt_valid`=1) sets the committed mapping of `cmt_arch` to `cmt_new` and makes `cmt_old` free from the next cycle on.
- R6: A flush makes the speculative map equal to the committed map, including a commit made in the same cycle. It makes free exactly those registers that the committed map does not hold. A group presented in a flush cycle is not accepted.
- R7: After reset, architectural register i maps to physical register i in both maps, and registers `ARCH_REGS` to `ARCH_REGS+SPEC_REGS-1` are free.
- R8: For each writer, `ren_prev` gives the physical register that held its destination mapping before this instruction, for release at retirement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grp_valid | input | GROUP_W | Lane carries an instruction |
| grp_has_dst | input | GROUP_W | Lane writes a destination register |
| grp_src_a | input | GROUP_W*AW | First source register per lane, lane i at bits [i*AW +: AW] |
| grp_src_b | input | GROUP_W*AW | Second source register per lane |
| grp_dst | input | GROUP_W*AW | Destination register per lane |
| grp_ready | output | 1 | Enough free registers for the group |
| ren_src_a | output | GROUP_W*PW | Physical tag of the first source, lane i at bits [i*PW +: PW] |
| ren_src_b | output | GROUP_W*PW | Physical tag of the second source |
| ren_dst | output | GROUP_W*PW | Newly allocated destination tag |
| ren_prev | output | GROUP_W*PW | Previous mapping of the destination |
| cmt_valid | input | 1 | Retire one writer this cycle |
| cmt_arch | input | AW | Destination register of the retiring writer |
| cmt_new | input | PW | Physical register that becomes architectural |
| cmt_old | input | PW | Physical register to release |
| flush | input | 1 | Discard all speculative mappings |

## Verification
The assertions check several properties on every cycle. Each allocated tag must come from the free pool, and tags within one group must differ. The free count must fall by exactly the group's writer count or rise by one per release. A cycle without acceptance, commit or flush must leave the pool unchanged. After a flush or reset the pool must hold exactly the spare registers. Other behaviours need the bench's reference model, which tracks both maps and the pool across thousands of mixed cycles. These are the exact lowest-first choice of tags, correct source translation with same-group forwarding, and previous tags. They also include reuse of released registers, stalls when the pool runs dry, and recovery that merges a same-cycle commit.

// File: rtl/rr_pkg.sv
package rr_pkg;
    localparam int ARCH_REGS = 32;
    localparam int SPEC_REGS = 41;
    localparam int PHYS_REGS = ARCH_REGS + SPEC_REGS;
    localparam int GROUP_W   = 2;
    localparam int AW = $clog2(ARCH_REGS);
    localparam int PW = $clog2(PHYS_REGS);
    localparam int CW = $clog2(PHYS_REGS + 1);
    localparam int NW = $clog2(GROUP_W + 1);

    typedef logic [AW-1:0] arch_t;
    typedef logic [PW-1:0] ptag_t;
    typedef logic [CW-1:0] cnt_t;
    typedef logic [NW-1:0] need_t;
    typedef logic [PHYS_REGS-1:0] pmask_t;

    typedef struct packed {
        logic  valid;
        logic  has_dst;
        arch_t src_a;
        arch_t src_b;
        arch_t dst;
    } lane_req_t;

    typedef struct packed {
        ptag_t src_a;
        ptag_t src_b;
        ptag_t dst;
        ptag_t prev;
    } lane_rsp_t;

    // index of the lowest set bit, zero when none is set
    function automatic ptag_t lowest_free(input pmask_t m);
        ptag_t r = '0;
        for (int i = PHYS_REGS - 1; i >= 0; i--)
            if (m[i]) r = ptag_t'(i);
        return r;
    endfunction

    function automatic cnt_t count_ones(input pmask_t m);
        cnt_t c = '0;
        for (int i = 0; i < PHYS_REGS; i++)
            c = c + cnt_t'(m[i]);
        return c;
    endfunction
endpackage

// File: rtl/rr_free_list.sv
module rr_free_list
    import rr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  need_t  take_n,
    input  logic   rel_en,
    input  ptag_t  rel_tag,
    input  logic   restore,
    input  pmask_t restore_mask,
    output ptag_t  pick [GROUP_W],
    output cnt_t   free_cnt,
    output pmask_t free_mask
);
    localparam pmask_t RESET_MASK = {{SPEC_REGS{1'b1}}, {ARCH_REGS{1'b0}}};

    pmask_t mask_q, mask_d, avail;

    // successive lowest-free picks, one per possible writer
    always_comb begin
        avail = mask_q;
        for (int k = 0; k < GROUP_W; k++) begin
            pick[k] = lowest_free(avail);
            avail[pick[k]] = 1'b0;
        end
    end

    always_comb begin
        mask_d = mask_q;
        for (int k = 0; k < GROUP_W; k++)
            if (need_t'(k) < take_n) mask_d[pick[k]] = 1'b0;
        if (rel_en) mask_d[rel_tag] = 1'b1;
        if (restore) mask_d = restore_mask;
    end

    always_ff @(posedge clk) begin
        if (rst) mask_q <= RESET_MASK;
        else     mask_q <= mask_d;
    end

    assign free_mask = mask_q;
    assign free_cnt  = count_ones(mask_q);
endmodule

// File: rtl/rr_map_table.sv
module rr_map_table
    import rr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  arch_t  rd_a [GROUP_W],
    input  arch_t  rd_b [GROUP_W],
    input  arch_t  rd_d [GROUP_W],
    output ptag_t  val_a [GROUP_W],
    output ptag_t  val_b [GROUP_W],
    output ptag_t  val_d [GROUP_W],
    input  logic [GROUP_W-1:0] wr_en,
    input  arch_t  wr_arch [GROUP_W],
    input  ptag_t  wr_tag [GROUP_W],
    input  logic   cmt_en,
    input  arch_t  cmt_arch,
    input  ptag_t  cmt_tag,
    input  logic   flush,
    output pmask_t live_mask
);
    ptag_t smap   [ARCH_REGS];
    ptag_t cmap   [ARCH_REGS];
    ptag_t cmap_d [ARCH_REGS];

    always_comb begin
        cmap_d = cmap;
        if (cmt_en) cmap_d[cmt_arch] = cmt_tag;
        live_mask = '0;
        for (int i = 0; i < ARCH_REGS; i++)
            live_mask[cmap_d[i]] = 1'b1;
    end

    for (genvar g = 0; g < GROUP_W; g++) begin : g_rd
        assign val_a[g] = smap[rd_a[g]];
        assign val_b[g] = smap[rd_b[g]];
        assign val_d[g] = smap[rd_d[g]];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ARCH_REGS; i++) begin
                smap[i] <= ptag_t'(i);
                cmap[i] <= ptag_t'(i);
            end
        end else begin
            cmap <= cmap_d;
            if (flush) begin
                smap <= cmap_d;
            end else begin
                // higher lane written last, so it wins on a shared target
                for (int k = 0; k < GROUP_W; k++)
                    if (wr_en[k]) smap[wr_arch[k]] <= wr_tag[k];
            end
        end
    end
endmodule

// File: rtl/reg_rename.sv
module reg_rename
    import rr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [GROUP_W-1:0]    grp_valid,
    input  logic [GROUP_W-1:0]    grp_has_dst,
    input  logic [GROUP_W*AW-1:0] grp_src_a,
    input  logic [GROUP_W*AW-1:0] grp_src_b,
    input  logic [GROUP_W*AW-1:0] grp_dst,
    output logic                  grp_ready,
    output logic [GROUP_W*PW-1:0] ren_src_a,
    output logic [GROUP_W*PW-1:0] ren_src_b,
    output logic [GROUP_W*PW-1:0] ren_dst,
    output logic [GROUP_W*PW-1:0] ren_prev,
    input  logic                  cmt_valid,
    input  logic [AW-1:0]         cmt_arch,
    input  logic [PW-1:0]         cmt_new,
    input  logic [PW-1:0]         cmt_old,
    input  logic                  flush
);
    lane_req_t req [GROUP_W];
    lane_rsp_t rsp [GROUP_W];
    arch_t  ra [GROUP_W], rb [GROUP_W], rd [GROUP_W];
    ptag_t  va [GROUP_W], vb [GROUP_W], vd [GROUP_W];
    ptag_t  pick [GROUP_W];
    ptag_t  dtag [GROUP_W];
    logic [GROUP_W-1:0] writes, wr_en;
    need_t  need;
    cnt_t   free_cnt;
    pmask_t free_mask, live_mask;
    logic   fire;

    for (genvar g = 0; g < GROUP_W; g++) begin : g_lane
        assign req[g] = '{valid:   grp_valid[g],
                          has_dst: grp_has_dst[g],
                          src_a:   grp_src_a[g*AW +: AW],
                          src_b:   grp_src_b[g*AW +: AW],
                          dst:     grp_dst[g*AW +: AW]};
        assign ra[g] = req[g].src_a;
        assign rb[g] = req[g].src_b;
        assign rd[g] = req[g].dst;
        assign writes[g] = req[g].valid & req[g].has_dst;
        assign ren_src_a[g*PW +: PW] = rsp[g].src_a;
        assign ren_src_b[g*PW +: PW] = rsp[g].src_b;
        assign ren_dst[g*PW +: PW]   = rsp[g].dst;
        assign ren_prev[g*PW +: PW]  = rsp[g].prev;
    end

    always_comb begin
        need = '0;
        for (int i = 0; i < GROUP_W; i++)
            need = need + need_t'(writes[i]);
    end

    assign grp_ready = (free_cnt >= cnt_t'(need));
    assign fire      = (|grp_valid) & grp_ready & ~flush;
    assign wr_en     = fire ? writes : '0;

    // tag assignment and same-group forwarding
    always_comb begin
        int slot;
        slot = 0;
        for (int i = 0; i < GROUP_W; i++) begin
            dtag[i] = '0;
            if (writes[i]) begin
                dtag[i] = pick[slot];
                slot = slot + 1;
            end
        end
        for (int i = 0; i < GROUP_W; i++) begin
            rsp[i] = '{src_a: va[i], src_b: vb[i], dst: dtag[i], prev: vd[i]};
            for (int j = 0; j < GROUP_W; j++) begin
                if (j < i && writes[j]) begin
                    if (req[j].dst == req[i].src_a) rsp[i].src_a = dtag[j];
                    if (req[j].dst == req[i].src_b) rsp[i].src_b = dtag[j];
                    if (req[j].dst == req[i].dst)   rsp[i].prev  = dtag[j];
                end
            end
        end
    end

    rr_free_list u_fl (
        .clk          (clk),
        .rst          (rst),
        .take_n       (fire ? need : '0),
        .rel_en       (cmt_valid),
        .rel_tag      (cmt_old),
        .restore      (flush),
        .restore_mask (~live_mask),
        .pick         (pick),
        .free_cnt     (free_cnt),
        .free_mask    (free_mask)
    );

    rr_map_table u_map (
        .clk       (clk),
        .rst       (rst),
        .rd_a      (ra),
        .rd_b      (rb),
        .rd_d      (rd),
        .val_a     (va),
        .val_b     (vb),
        .val_d     (vd),
        .wr_en     (wr_en),
        .wr_arch   (rd),
        .wr_tag    (dtag),
        .cmt_en    (cmt_valid),
        .cmt_arch  (cmt_arch),
        .cmt_tag   (cmt_new),
        .flush     (flush),
        .live_mask (live_mask)
    );
endmodule

// File: rtl/reg_rename_chk.sv
module reg_rename_chk
    import rr_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  fire,
    input logic                  flush,
    input logic                  cmt_valid,
    input need_t                 need,
    input logic [GROUP_W-1:0]    wr_en,
    input logic [GROUP_W*PW-1:0] dst_tags,
    input pmask_t                free_mask,
    input cnt_t                  free_cnt
);
    for (genvar i = 0; i < GROUP_W; i++) begin : g_i
        // R1
        alloc_was_free_chk: assert property (@(posedge clk) disable iff (rst)
            wr_en[i] |-> free_mask[dst_tags[i*PW +: PW]]);
        for (genvar j = i + 1; j < GROUP_W; j++) begin : g_j
            // R1
            alloc_distinct_chk: assert property (@(posedge clk) disable iff (rst)
                (wr_en[i] && wr_en[j]) |-> (dst_tags[i*PW +: PW] != dst_tags[j*PW +: PW]));
        end
    end

    // R4
    alloc_count_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && !cmt_valid && !flush) |=>
            (int'(free_cnt) == int'($past(free_cnt)) - int'($past(need))));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!fire && !cmt_valid && !flush) |=> $stable(free_mask));

    // R5
    release_count_chk: assert property (@(posedge clk) disable iff (rst)
        (cmt_valid && !fire && !flush) |=> (int'(free_cnt) == int'($past(free_cnt)) + 1));

    // R6
    flush_pool_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (int'(free_cnt) == SPEC_REGS));

    // R7
    reset_pool_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (int'(free_cnt) == SPEC_REGS));
endmodule

bind reg_rename reg_rename_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .fire      (fire),
    .flush     (flush),
    .cmt_valid (cmt_valid),
    .need      (need),
    .wr_en     (wr_en),
    .dst_tags  (ren_dst),
    .free_mask (free_mask),
    .free_cnt  (free_cnt)
);

// File: tb/reg_rename_tb_top.sv
module reg_rename_tb_top;
    import rr_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int GW = GROUP_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [GW-1:0]    grp_valid = '0, grp_has_dst = '0;
    logic [GW*AW-1:0] grp_src_a = '0, grp_src_b = '0, grp_dst = '0;
    logic             grp_ready;
    logic [GW*PW-1:0] ren_src_a, ren_src_b, ren_dst, ren_prev;
    logic             cmt_valid = 1'b0;
    logic [AW-1:0]    cmt_arch = '0;
    logic [PW-1:0]    cmt_new = '0, cmt_old = '0;
    logic             flush = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    reg_rename dut_i (
        .clk(clk), .rst(rst),
        .grp_valid(grp_valid), .grp_has_dst(grp_has_dst),
        .grp_src_a(grp_src_a), .grp_src_b(grp_src_b), .grp_dst(grp_dst),
        .grp_ready(grp_ready),
        .ren_src_a(ren_src_a), .ren_src_b(ren_src_b), .ren_dst(ren_dst), .ren_prev(ren_prev),
        .cmt_valid(cmt_valid), .cmt_arch(cmt_arch), .cmt_new(cmt_new), .cmt_old(cmt_old),
        .flush(flush)
    );

    int errors = 0;
    int checks = 0;

    // reference model state
    int smap [ARCH_REGS];
    int cmap [ARCH_REGS];
    bit freeb [PHYS_REGS];
    int q_arch[$], q_new[$], q_old[$];

    // stimulus for the next group
    bit lv [GW], lh [GW];
    int la [GW], lb [GW], ld [GW];
    string tag_force = "";

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic string pick_tag(input string dflt);
        return (tag_force != "") ? tag_force : dflt;
    endfunction

    task automatic model_reset();
        for (int a = 0; a < ARCH_REGS; a++) begin
            smap[a] = a;
            cmap[a] = a;
        end
        for (int p = 0; p < PHYS_REGS; p++) freeb[p] = (p >= ARCH_REGS);
        q_arch.delete(); q_new.delete(); q_old.delete();
    endtask

    task automatic cycle(input bit do_cmt, input bit do_flush);
        int  need, nfree, e_a, e_b, e_d, e_p;
        bit  any, fire, byp_a, byp_b, byp_p, cv;
        int  tmap [ARCH_REGS];
        bit  tfree [PHYS_REGS];
        int  c_arch, c_new, c_old;
        @(negedge clk);
        for (int i = 0; i < GW; i++) begin
            grp_valid[i]   = lv[i];
            grp_has_dst[i] = lh[i];
            grp_src_a[i*AW +: AW] = AW'(la[i]);
            grp_src_b[i*AW +: AW] = AW'(lb[i]);
            grp_dst[i*AW +: AW]   = AW'(ld[i]);
        end
        cv = do_cmt && (q_arch.size() > 0);
        c_arch = cv ? q_arch[0] : 0;
        c_new  = cv ? q_new[0] : 0;
        c_old  = cv ? q_old[0] : 0;
        cmt_valid = cv;
        cmt_arch  = AW'(c_arch);
        cmt_new   = PW'(c_new);
        cmt_old   = PW'(c_old);
        flush     = do_flush;
        #1;
        need = 0; nfree = 0; any = 0;
        for (int i = 0; i < GW; i++) begin
            any = any | lv[i];
            if (lv[i] && lh[i]) need++;
        end
        for (int p = 0; p < PHYS_REGS; p++) if (freeb[p]) nfree++;
        // R4: ready when the pool covers every writer
        chk(pick_tag("R4"), "grp_ready", int'(grp_ready), int'(nfree >= need));
        fire = any && (nfree >= need) && !do_flush;
        tmap = smap;
        tfree = freeb;
        if (fire) begin
            for (int i = 0; i < GW; i++) begin
                if (!lv[i]) continue;
                byp_a = 0; byp_b = 0; byp_p = 0;
                for (int j = 0; j < i; j++) begin
                    if (lv[j] && lh[j] && ld[j] == la[i]) byp_a = 1;
                    if (lv[j] && lh[j] && ld[j] == lb[i]) byp_b = 1;
                    if (lv[j] && lh[j] && ld[j] == ld[i]) byp_p = 1;
                end
                e_a = tmap[la[i]];
                e_b = tmap[lb[i]];
                chk(pick_tag(byp_a ? "R3" : "R2"), "src_a tag", int'(ren_src_a[i*PW +: PW]), e_a);
                chk(pick_tag(byp_b ? "R3" : "R2"), "src_b tag", int'(ren_src_b[i*PW +: PW]), e_b);
                if (lh[i]) begin
                    e_d = -1;
                    for (int p = PHYS_REGS - 1; p >= 0; p--) if (tfree[p]) e_d = p;
                    e_p = tmap[ld[i]];
                    chk(pick_tag("R1"), "dst tag", int'(ren_dst[i*PW +: PW]), e_d);
                    chk(pick_tag(byp_p ? "R3" : "R8"), "prev tag", int'(ren_prev[i*PW +: PW]), e_p);
                    tfree[e_d] = 0;
                    tmap[ld[i]] = e_d;
                    q_arch.push_back(ld[i]);
                    q_new.push_back(e_d);
                    q_old.push_back(e_p);
                end
            end
            smap = tmap;
            freeb = tfree;
        end
        if (cv) begin
            // R5: committed map update and release of the displaced register
            cmap[c_arch] = c_new;
            freeb[c_old] = 1;
            void'(q_arch.pop_front()); void'(q_new.pop_front()); void'(q_old.pop_front());
        end
        if (do_flush) begin
            // R6: recovery to the committed map
            smap = cmap;
            for (int p = 0; p < PHYS_REGS; p++) freeb[p] = 1;
            for (int a = 0; a < ARCH_REGS; a++) freeb[cmap[a]] = 0;
            q_arch.delete(); q_new.delete(); q_old.delete();
        end
    endtask

    task automatic set_lane(input int i, input bit v, input bit h, input int a, input int b, input int d);
        lv[i] = v; lh[i] = h; la[i] = a; lb[i] = b; ld[i] = d;
    endtask

    task automatic idle_lanes();
        for (int i = 0; i < GW; i++) set_lane(i, 0, 0, 0, 0, 0);
    endtask

    task automatic rand_lanes(input int range);
        for (int i = 0; i < GW; i++)
            set_lane(i, ($urandom % 4) != 0, ($urandom % 3) != 0,
                     int'($urandom % range), int'($urandom % range), int'($urandom % range));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        idle_lanes();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R7: first group sees identity maps and the lowest spare register
        tag_force = "R7";
        set_lane(0, 1, 1, 5, 31, 2);
        set_lane(1, 1, 1, 2, 0, 9);
        cycle(0, 0);
        tag_force = "";

        // R3: second lane reads and overwrites what the first lane writes
        set_lane(0, 1, 1, 4, 4, 4);
        set_lane(1, 1, 1, 4, 4, 4);
        cycle(0, 0);
        set_lane(0, 1, 1, 4, 2, 7);
        set_lane(1, 1, 0, 7, 4, 7);
        cycle(0, 0);

        // R4: drain the pool without commits until groups stall
        for (int n = 0; n < 22; n++) begin
            set_lane(0, 1, 1, n % 8, (n + 3) % 8, n % 5);
            set_lane(1, 1, 1, (n + 1) % 8, n % 8, (n + 2) % 5);
            cycle(0, 0);
        end
        set_lane(0, 1, 1, 1, 2, 3);
        set_lane(1, 0, 0, 0, 0, 0);
        cycle(0, 0);
        cycle(0, 0);

        // R5: retire some writers, then reuse the released registers
        idle_lanes();
        for (int n = 0; n < 6; n++) cycle(1, 0);
        for (int n = 0; n < 6; n++) begin
            rand_lanes(8);
            cycle(1, 0);
        end

        // R6: flush with a same-cycle commit and a presented group
        rand_lanes(8);
        cycle(1, 1);
        rand_lanes(8);
        cycle(0, 0);

        // mixed random traffic
        for (int n = 0; n < 4000; n++) begin
            rand_lanes((n % 2 == 0) ? 6 : ARCH_REGS);
            cycle(($urandom % 10) < 6, ($urandom % 60) == 0);
        end

        idle_lanes();
        cycle(1, 1);
        cycle(0, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule